// File: doc/BRIEF.md
# Cascadable Synchronous Decade Counter

A single decimal digit counter that steps through 0 to 9 on rising clock edges and wraps to 0. Its value can be cleared to zero at any moment by an active-low asynchronous clear input. It can also be preset on the next clock edge from a 4-bit data input by an active-low synchronous load. Counting needs two enables to be high together. One of them, the chain enable, also gates the terminal-count carry, which is a combinational output.

To build a wider decimal counter, place several digits side by side. Tie each higher digit's two enables to the carry of the digit below it. Every digit then advances on the same clock edge without any extra gating. The clear, load and data inputs are shared or driven per digit as needed.

Top module: `bcd_decade_counter`

## Requirements
- R1: While clr_n is low, count is 0 at once, without waiting for a clock edge, whatever ld_n, cnt_en and chain_en are.
- R2: With clr_n high and ld_n low at a rising edge, count takes the value of din after that edge, whatever cnt_en and chain_en are.
- R3: With clr_n high, ld_n high and both cnt_en and chain_en high at a rising edge, a count below 9 grows by one.
- R4: Under the same conditions as R3, a count of 9 becomes 0, which gives the decimal sequence 0..9.
- R5: With clr_n high and ld_n high, a rising edge leaves count unchanged when either cnt_en or chain_en is low.
- R6: carry_out is high exactly when chain_en is high and count equals 9. cnt_en has no influence on carry_out.
- R7: A loaded value from 10 to 15 keeps carry_out low, and the next enabled count step makes count 0.
- R8: Three digits chained carry-to-enables form a decimal counter that passes 000..999 and rolls from 999 to 000 in one edge.
- R9: clr_n low overrides a simultaneous low ld_n: count stays 0 across the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| ld_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable that does not reach the carry |
| chain_en | input | 1 | Count enable that also gates carry_out |
| din | input | 4 | Preset value, taken while ld_n is low |
| count | output | 4 | Current digit value |
| carry_out | output | 1 | Terminal-count carry, high at 9 while chain_en is high |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is load and count: the bench holds ld_n low while both enables are high, and the result must be the loaded value rather than the increment. The second pair is clear and load: the bench drops clr_n halfway through a cycle while ld_n is low. The count must read zero in that same half cycle and must still be zero after the edge. A behavioural model of the three-digit chain judges every edge. The model tracks the digits with integers.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
    localparam int DIGIT_W = 4;
    localparam int RADIX   = 10;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2
    } act_e;
endpackage

// File: rtl/bcd_step.sv
module bcd_step #(
    parameter int W     = bcd_cnt_pkg::DIGIT_W,
    parameter int RADIX = bcd_cnt_pkg::RADIX
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] TERM = W'(RADIX - 1);

    // Terminal and out-of-range values both fall back to zero.
    always_comb begin
        if (cur >= TERM) nxt = '0;
        else             nxt = cur + 1'b1;
    end
endmodule

// File: rtl/bcd_carry_gen.sv
module bcd_carry_gen #(
    parameter int W     = bcd_cnt_pkg::DIGIT_W,
    parameter int RADIX = bcd_cnt_pkg::RADIX
) (
    input  logic [W-1:0] cur,
    input  logic         chain_en,
    output logic         carry
);
    localparam logic [W-1:0] TERM = W'(RADIX - 1);

    assign carry = chain_en & (cur == TERM);
endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter #(
    parameter int W     = bcd_cnt_pkg::DIGIT_W,
    parameter int RADIX = bcd_cnt_pkg::RADIX
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         ld_n,
    input  logic         cnt_en,
    input  logic         chain_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] count,
    output logic         carry_out
);
    import bcd_cnt_pkg::*;

    typedef struct packed {
        logic [W-1:0] value;
    } cnt_state_t;

    cnt_state_t    state_d, state_q;
    act_e          act;
    logic [W-1:0]  stepped;

    bcd_step #(.W(W), .RADIX(RADIX)) u_step (
        .cur (state_q.value),
        .nxt (stepped)
    );

    bcd_carry_gen #(.W(W), .RADIX(RADIX)) u_carry (
        .cur      (state_q.value),
        .chain_en (chain_en),
        .carry    (carry_out)
    );

    // Load outranks counting; clear is handled in the register.
    always_comb begin
        if (!ld_n)                  act = ACT_LOAD;
        else if (cnt_en && chain_en) act = ACT_STEP;
        else                        act = ACT_HOLD;
    end

    always_comb begin
        state_d = state_q;
        unique case (act)
            ACT_LOAD: state_d.value = din;
            ACT_STEP: state_d.value = stepped;
            default:  state_d.value = state_q.value;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign count = state_q.value;
endmodule

// File: rtl/bcd_decade_counter_chk.sv
module bcd_decade_counter_chk #(
    parameter int W     = bcd_cnt_pkg::DIGIT_W,
    parameter int RADIX = bcd_cnt_pkg::RADIX
) (
    input logic         clk,
    input logic         clr_n,
    input logic         ld_n,
    input logic         cnt_en,
    input logic         chain_en,
    input logic [W-1:0] din,
    input logic [W-1:0] count,
    input logic         carry_out
);
    localparam logic [W-1:0] TERM = W'(RADIX - 1);

    p_clear_zero_r1: assert property (@(posedge clk)
        !clr_n |-> count == '0);

    p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
        !ld_n |=> count == $past(din));

    p_step_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && cnt_en && chain_en && count < TERM) |=> count == W'($past(count) + 1'b1));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && cnt_en && chain_en && count >= TERM) |=> count == '0);

    p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && !(cnt_en && chain_en)) |=> $stable(count));

    p_carry_gate_r6: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out |-> (chain_en && count == TERM));

    p_carry_term_r6: assert property (@(posedge clk) disable iff (!clr_n)
        (chain_en && count == TERM) |-> carry_out);

    p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (!clr_n)
        count > TERM |-> !carry_out);
endmodule

bind bcd_decade_counter bcd_decade_counter_chk #(.W(W), .RADIX(RADIX)) u_chk (.*);

// File: tb/bcd_decade_counter_tb.sv
`timescale 1ns/1ps
module bcd_decade_counter_tb;
    logic clk = 1'b0;
    logic clr_n = 1'b0;
    logic ld_n = 1'b1;
    logic pe_in = 1'b0;
    logic te_in = 1'b0;
    logic [3:0] din0 = '0, din1 = '0, din2 = '0;
    logic [3:0] q0, q1, q2;
    logic c0, c1, c2;

    int compared = 0;
    int mismatched = 0;
    string cur_req = "R1";
    int m0 = 0, m1 = 0, m2 = 0;

    always #2 clk = ~clk;

    // Digit 0 sees the two enables separately; higher digits use the chain (R8).
    bcd_decade_counter u_dut (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .cnt_en(pe_in), .chain_en(te_in),
        .din(din0), .count(q0), .carry_out(c0));
    bcd_decade_counter u_dut_mid (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .cnt_en(c0), .chain_en(c0),
        .din(din1), .count(q1), .carry_out(c1));
    bcd_decade_counter u_dut_top (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .cnt_en(c1), .chain_en(c1),
        .din(din2), .count(q2), .carry_out(c2));

    function automatic int adv(input int x);
        return (x >= 9) ? 0 : x + 1;
    endfunction

    // Behavioural reference of the three-digit chain.
    always @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            m0 = 0; m1 = 0; m2 = 0;
        end else if (!ld_n) begin
            m0 = int'(din0); m1 = int'(din1); m2 = int'(din2);
        end else begin
            bit k0, k1, s0;
            s0 = pe_in && te_in;
            k0 = te_in && (m0 == 9);
            k1 = k0 && (m1 == 9);
            if (s0) m0 = adv(m0);
            if (k0) m1 = adv(m1);
            if (k1) m2 = adv(m2);
        end
    end

    task automatic compare_all(input string tag);
        bit e0, e1, e2;
        e0 = te_in && (m0 == 9);
        e1 = e0 && (m1 == 9);
        e2 = e1 && (m2 == 9);
        compared++;
        if (int'(q0) != m0 || int'(q1) != m1 || int'(q2) != m2 ||
            c0 != e0 || c1 != e1 || c2 != e2) begin
            mismatched++;
            $display("FAIL %s t=%0t count=%0d%0d%0d carry=%b%b%b expected count=%0d%0d%0d carry=%b%b%b",
                     tag, $time, q2, q1, q0, c2, c1, c0, m2, m1, m0, e2, e1, e0);
        end
    endtask

    always @(posedge clk) begin
        #1;
        compare_all(cur_req);
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load3(input int h, input int t, input int u, input bit pe, input bit te);
        @(negedge clk);
        din2 = 4'(h); din1 = 4'(t); din0 = 4'(u);
        pe_in = pe; te_in = te; ld_n = 1'b0;
        @(negedge clk);
        ld_n = 1'b1;
    endtask

    bit done = 1'b0;

    initial begin
        #(200000 * 4);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired (actual hung, expected finish)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        run(3);
        @(negedge clk); clr_n = 1'b1;

        // R3 R4 R8: free-running chain through 999 -> 000
        cur_req = "R8";
        pe_in = 1'b1; te_in = 1'b1;
        run(1205);

        // R2: load while enabled, then while disabled
        cur_req = "R2";
        load3(4, 5, 6, 1'b1, 1'b1);
        run(3);
        load3(7, 2, 3, 1'b0, 1'b0);
        run(2);

        // R5 R6: one enable at a time, digit at its terminal value
        cur_req = "R5";
        load3(0, 3, 9, 1'b0, 1'b1);
        cur_req = "R6";
        run(4);
        cur_req = "R5";
        @(negedge clk); pe_in = 1'b1; te_in = 1'b0;
        run(4);
        cur_req = "R6";
        @(negedge clk); pe_in = 1'b0; te_in = 1'b0;
        run(2);

        // R4: single wrap step with all enables
        cur_req = "R4";
        load3(1, 1, 8, 1'b1, 1'b1);
        run(4);

        // R7: illegal values recover to zero, carry stays low
        cur_req = "R7";
        load3(0, 0, 13, 1'b0, 1'b1);
        run(2);
        @(negedge clk); pe_in = 1'b1;
        run(3);
        load3(0, 4, 15, 1'b1, 1'b1);
        run(2);

        // R1 R9: clear in mid cycle while a load is requested
        cur_req = "R9";
        @(negedge clk);
        din2 = 4'd8; din1 = 4'd8; din0 = 4'd8; ld_n = 1'b0;
        #0.5 clr_n = 1'b0;
        #0.5;
        compared++;
        if (q0 != 4'd0 || q1 != 4'd0 || q2 != 4'd0) begin
            mismatched++;
            $display("FAIL R1 mid-cycle clear count=%0d%0d%0d expected 000", q2, q1, q0);
        end
        run(2);
        @(negedge clk); clr_n = 1'b1; ld_n = 1'b1;
        cur_req = "R3";
        pe_in = 1'b1; te_in = 1'b1;
        run(25);

        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule